// File: doc/BRIEF.md
# Laplacian Sharpening Filter

This block sharpens a raster greyscale stream in flight. It takes one pixel on each cycle in which the source marks the input valid. A start-of-frame flag comes with the first pixel of a frame, and an end-of-line flag comes with the last pixel of each row. For every interior pixel the block returns five times that pixel minus the sum of its four edge-adjacent neighbours (up, down, left, right). The result is clamped to the pixel range. This equals the original pixel minus its four-neighbour Laplacian, so edges gain contrast and flat or linearly shaded areas stay the same. Pixels on the outer ring of the frame leave the block unchanged. A colour stream is sharpened by running one copy of the block per channel.

Two one-line delay memories and a short set of window registers bring the row above, the current row and the row below into line at the same column. The output for a pixel can only be formed once the pixel below it and one more pixel have arrived. The output therefore trails the input by one line plus one pixel of stream positions, plus two clock cycles. When the last pixel of a frame has arrived, the block advances itself on idle input cycles to push out the remaining line and one pixel. If the next frame starts instead, that frame's own pixels push them out.

Top module: `lapl_sharpen`

## Requirements
- R1: For a pixel not on the frame edge, with centre value c and edge neighbours u, d, l, r, outPix equals 5*c - (u + d + l + r) when that value lies between 0 and 255.
- R2: When 5*c - (u + d + l + r) is below 0, outPix is 0. When it is above 255, outPix is 255.
- R3: Pixels in row 0, row FRAME_H-1, column 0 and column FRAME_W-1 are output equal to their input value.
- R4: Every frame yields exactly FRAME_W*FRAME_H output pixels in raster order. outSof is high only with the pixel at row 0, column 0. outEol is high only with pixels in column FRAME_W-1. Neither flag is high without outValid.
- R5: Each accepted input pixel or internal drain cycle is one stream position. The output for stream position j appears with outValid, as a one-cycle pulse, two clock cycles after stream position j+FRAME_W+1 is processed.
- R6: A cycle with inValid low, outside a drain, changes no state. outValid stays low in the cycles that depend on it, and any gap length between pixels gives the same results.
- R7: Frame position is counted from the markers. inSof puts its pixel in row 0, each inEol ends a row, and inEol while in row FRAME_H-1 ends the frame. On each idle cycle after the frame ends, one internal drain cycle runs, up to FRAME_W+1 of them, so that the last FRAME_W+1 outputs come out with no further input.
- R8: After reset, outValid stays low until FRAME_W+2 stream positions have been processed.
- R9: If the next frame starts before the drain has finished, that frame's pixels carry out the remaining outputs of the earlier frame. Both frames are filtered correctly, even with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input pixel present this cycle |
| inPix | input | PIX_W | Input pixel value |
| inSof | input | 1 | Input pixel is the first of a frame |
| inEol | input | 1 | Input pixel is the last of its row |
| outValid | output | 1 | Output pixel present this cycle |
| outPix | output | PIX_W | Sharpened pixel value |
| outSof | output | 1 | Output pixel is row 0, column 0 |
| outEol | output | 1 | Output pixel is in the last column |

## Verification
The bench sends a checkerboard of full-scale values, so the kernel hits both clamp limits. A design that wraps the sum instead of clamping shows bright specks in dark areas, and the reverse. It also sends a linear ramp, where the correct output equals the input. A mix-up of window taps, such as using a diagonal or the wrong row, breaks that identity.

Frames arrive with random gaps, with a short idle spell that ends the drain early, with a full idle drain, and with frames back to back. A design that advanced on idle cycles at the wrong moment would shift later frames by some columns. A design that did not drain would lose the last row. Edge pixels are compared against their input values, which catches an edge test that is off by one row or column. An early outValid in the fill period after reset is caught cycle by cycle.

// File: rtl/lapl_pkg.sv
package lapl_pkg;

  // Strobes from the sequencer to the datapath for one clock cycle
  typedef struct packed {
    logic advance;   // shift line memories and window by one position
    logic isReal;    // the position being shifted in carries a real pixel
    logic emit;      // window centre is a real pixel: load output registers
    logic border;    // that centre sits on the frame edge
    logic sof;       // that centre is row 0, column 0
    logic eol;       // that centre is in the last column
  } ctl_t;

endpackage

// File: rtl/lapl_linebuf.sv
module lapl_linebuf #(
  parameter int DEPTH = 320,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wData,
  output logic [DW-1:0] rData
);

  logic [DW-1:0] mem [DEPTH];

  // read-before-write at one address: the value leaving is DEPTH positions old
  always_ff @(posedge clk) begin
    if (en) begin
      rData     <= mem[addr];
      mem[addr] <= wData;
    end
  end

endmodule

// File: rtl/lapl_kernel.sv
module lapl_kernel #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] centre,
  input  logic [PIX_W-1:0] up,
  input  logic [PIX_W-1:0] down,
  input  logic [PIX_W-1:0] left,
  input  logic [PIX_W-1:0] right,
  output logic [PIX_W-1:0] sharp
);

  localparam int SW   = PIX_W + 4;
  localparam int MAXV = (1 << PIX_W) - 1;

  logic signed [SW-1:0] cS, fiveC, nbrSum, acc;

  always_comb begin
    cS     = $signed(SW'(centre));
    fiveC  = (cS <<< 2) + cS;
    nbrSum = $signed(SW'(up) + SW'(down) + SW'(left) + SW'(right));
    acc    = fiveC - nbrSum;
    if (acc[SW-1])
      sharp = '0;
    else if (acc > $signed(SW'(MAXV)))
      sharp = PIX_W'(MAXV);
    else
      sharp = acc[PIX_W-1:0];
  end

endmodule

// File: rtl/lapl_ctrl.sv
module lapl_ctrl
  import lapl_pkg::*;
#(
  parameter int FRAME_W = 320,
  parameter int FRAME_H = 240
) (
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  input  logic inSof,
  input  logic inEol,
  input  logic centreReal,
  output ctl_t ctl
);

  localparam int RW      = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;
  localparam int CW      = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam int DRAIN_N = FRAME_W + 1;
  localparam int DRW     = $clog2(DRAIN_N + 1);
  localparam int FILL_N  = FRAME_W + 2;
  localparam int FW      = $clog2(FILL_N + 1);

  logic [RW-1:0]  inRow, rowNow, outRow;
  logic [CW-1:0]  outCol;
  logic           frameOpen, fire, adv, lastPix, primed, emit;
  logic [DRW-1:0] drainLeft;
  logic [FW-1:0]  fillCnt;

  always_comb begin
    rowNow  = inSof ? '0 : inRow;
    lastPix = inValid && inEol && (rowNow == RW'(FRAME_H - 1));
    adv     = inValid || (!frameOpen && (drainLeft != '0));
    primed  = (fillCnt == FW'(FILL_N));
    emit    = fire && primed && centreReal;
  end

  // input side: row tracking, frame end and drain budget
  always_ff @(posedge clk) begin
    if (rst) begin
      inRow     <= '0;
      frameOpen <= 1'b0;
      drainLeft <= '0;
      fillCnt   <= '0;
      fire      <= 1'b0;
    end else begin
      fire <= adv;
      if (adv && !primed)
        fillCnt <= fillCnt + 1'b1;
      if (inValid) begin
        frameOpen <= !lastPix;
        if (inEol)
          inRow <= lastPix ? '0 : rowNow + 1'b1;
        else
          inRow <= rowNow;
      end
      if (lastPix)
        drainLeft <= DRW'(DRAIN_N);
      else if (adv && (drainLeft != '0))
        drainLeft <= drainLeft - 1'b1;
    end
  end

  // output side: raster position of the next pixel to leave
  always_ff @(posedge clk) begin
    if (rst) begin
      outRow <= '0;
      outCol <= '0;
    end else if (emit) begin
      if (outCol == CW'(FRAME_W - 1)) begin
        outCol <= '0;
        outRow <= (outRow == RW'(FRAME_H - 1)) ? '0 : outRow + 1'b1;
      end else begin
        outCol <= outCol + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.advance = adv;
    ctl.isReal  = inValid;
    ctl.emit    = emit;
    ctl.border  = (outRow == '0) || (outRow == RW'(FRAME_H - 1)) ||
                  (outCol == '0) || (outCol == CW'(FRAME_W - 1));
    ctl.sof     = (outRow == '0) && (outCol == '0);
    ctl.eol     = (outCol == CW'(FRAME_W - 1));
  end

endmodule

// File: rtl/lapl_datapath.sv
module lapl_datapath
  import lapl_pkg::*;
#(
  parameter int FRAME_W = 320,
  parameter int PIX_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_t             ctl,
  input  logic [PIX_W-1:0] inPix,
  output logic             centreReal,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix,
  output logic             outSof,
  output logic             outEol
);

  localparam int AW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam int TW = PIX_W + 1;

  logic [AW-1:0]    ptr;
  logic [TW-1:0]    midRight;   // row n, one column right of centre (tagged)
  logic [TW-1:0]    midCentre;  // row n, centre column (tagged)
  logic [PIX_W-1:0] midLeft;
  logic [PIX_W-1:0] upPix;      // row n-1, centre column
  logic [PIX_W-1:0] lowNew, lowPix;
  logic [PIX_W-1:0] sharp;

  // one line delay, tag bit marks real versus drain positions
  lapl_linebuf #(.DEPTH(FRAME_W), .DW(TW)) lineMid_i (
    .clk(clk), .en(ctl.advance), .addr(ptr),
    .wData({ctl.isReal, inPix}), .rData(midRight)
  );

  // second line delay fed from the first one's output
  lapl_linebuf #(.DEPTH(FRAME_W), .DW(PIX_W)) lineUp_i (
    .clk(clk), .en(ctl.advance), .addr(ptr),
    .wData(midRight[PIX_W-1:0]), .rData(upPix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      lowNew    <= '0;
      lowPix    <= '0;
      midCentre <= '0;
      midLeft   <= '0;
    end else if (ctl.advance) begin
      ptr       <= (ptr == AW'(FRAME_W - 1)) ? '0 : ptr + 1'b1;
      lowNew    <= inPix;
      lowPix    <= lowNew;
      midCentre <= midRight;
      midLeft   <= midCentre[PIX_W-1:0];
    end
  end

  assign centreReal = midCentre[PIX_W];

  lapl_kernel #(.PIX_W(PIX_W)) kernel_i (
    .centre(midCentre[PIX_W-1:0]), .up(upPix), .down(lowPix),
    .left(midLeft), .right(midRight[PIX_W-1:0]), .sharp(sharp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outPix   <= '0;
      outSof   <= 1'b0;
      outEol   <= 1'b0;
    end else begin
      outValid <= ctl.emit;
      outSof   <= ctl.emit && ctl.sof;
      outEol   <= ctl.emit && ctl.eol;
      if (ctl.emit)
        outPix <= ctl.border ? midCentre[PIX_W-1:0] : sharp;
    end
  end

endmodule

// File: rtl/lapl_sharpen.sv
module lapl_sharpen
  import lapl_pkg::*;
#(
  parameter int FRAME_W = 320,
  parameter int FRAME_H = 240,
  parameter int PIX_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [PIX_W-1:0] inPix,
  input  logic             inSof,
  input  logic             inEol,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix,
  output logic             outSof,
  output logic             outEol
);

  ctl_t ctl;
  logic centreReal;

  lapl_ctrl #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof),
    .inEol(inEol), .centreReal(centreReal), .ctl(ctl)
  );

  lapl_datapath #(.FRAME_W(FRAME_W), .PIX_W(PIX_W)) dp_i (
    .clk(clk), .rst(rst), .ctl(ctl), .inPix(inPix),
    .centreReal(centreReal), .outValid(outValid), .outPix(outPix),
    .outSof(outSof), .outEol(outEol)
  );

endmodule

// File: rtl/lapl_sharpen_chk.sv
module lapl_sharpen_chk #(
  parameter int FRAME_W = 320,
  parameter int FRAME_H = 240
) (
  input logic clk,
  input logic rst,
  input logic inValid,
  input logic outValid,
  input logic outSof,
  input logic outEol
);

  localparam int CW     = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam int PIXN   = FRAME_W * FRAME_H;
  localparam int PNW    = $clog2(PIXN + 1);
  localparam int FILL_N = FRAME_W + 2;
  localparam int FW     = $clog2(FILL_N + 1);

  logic [CW-1:0]  colCnt;
  logic [PNW-1:0] frameCnt;
  logic [FW-1:0]  realCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      colCnt   <= '0;
      frameCnt <= '0;
      realCnt  <= '0;
    end else begin
      if (inValid && (realCnt != FW'(FILL_N)))
        realCnt <= realCnt + 1'b1;
      if (outValid) begin
        colCnt   <= (colCnt == CW'(FRAME_W - 1)) ? '0 : colCnt + 1'b1;
        frameCnt <= (frameCnt == PNW'(PIXN - 1)) ? '0 : frameCnt + 1'b1;
      end
    end
  end

  // R4
  marker_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (outSof || outEol) |-> outValid);

  // R4
  eol_column_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outEol == (colCnt == CW'(FRAME_W - 1))));

  // R4
  sof_position_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outSof == (frameCnt == '0)));

  // R8
  no_early_out_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (realCnt >= FW'(FRAME_W + 1)));

endmodule

bind lapl_sharpen lapl_sharpen_chk #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .outValid(outValid),
  .outSof(outSof), .outEol(outEol)
);

// File: tb/lapl_sharpen_tb.sv
`timescale 1ns/1ps
module lapl_sharpen_tb_top;

  localparam int W  = 8;
  localparam int H  = 6;
  localparam int NF = 6;
  localparam int PN = W * H;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [7:0] inPix = '0;
  logic       inSof = 1'b0;
  logic       inEol = 1'b0;
  logic       outValid, outSof, outEol;
  logic [7:0] outPix;

  always #2.5 clk = ~clk;

  lapl_sharpen #(.FRAME_W(W), .FRAME_H(H), .PIX_W(8)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inPix(inPix), .inSof(inSof),
    .inEol(inEol), .outValid(outValid), .outPix(outPix), .outSof(outSof),
    .outEol(outEol)
  );

  int tests = 0, fails = 0, outCount = 0;
  bit done = 1'b0;
  int img [NF][H][W];
  int hist [$];
  bit mOpen = 1'b0;
  int mDrain = 0;
  int unsigned seed = 32'h1234_5678;

  // expected-output pipe, two cycles deep
  bit    eV [2];
  int    ePix [2];
  bit    eSof [2], eEol [2];
  string eTag [2], eTrig [2];

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hff);
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_pixel(int e, output int v, output string tag, output bit s, output bit l);
    int f, idx, r, c, acc;
    f = e / PN; idx = e % PN; r = idx / W; c = idx % W;
    s = (r == 0 && c == 0);
    l = (c == W - 1);
    if (r == 0 || r == H - 1 || c == 0 || c == W - 1) begin
      v = img[f][r][c]; tag = "R3";
    end else begin
      acc = 5 * img[f][r][c] - img[f][r-1][c] - img[f][r+1][c]
            - img[f][r][c-1] - img[f][r][c+1];
      if (acc < 0)        begin v = 0;   tag = "R2"; end
      else if (acc > 255) begin v = 255; tag = "R2"; end
      else                begin v = acc; tag = "R1"; end
    end
  endtask

  task automatic step(bit v, int pix, bit sof, bit eol, int fid, int idx);
    bit adv, carry;
    int pos;
    @(negedge clk);
    // compare what the design shows now against the prediction of two cycles ago
    if (outValid) outCount++;
    if (eV[1]) begin
      chk(outValid === 1'b1, eTrig[1], "outValid", int'(outValid), 1);
      if (outValid) begin
        chk(outPix == 8'(ePix[1]), eTag[1], "outPix", int'(outPix), ePix[1]);
        chk(outSof == eSof[1], "R4", "outSof", int'(outSof), int'(eSof[1]));
        chk(outEol == eEol[1], "R4", "outEol", int'(outEol), int'(eEol[1]));
      end
    end else begin
      chk(outValid === 1'b0, (hist.size() < W + 3) ? "R8" : "R6", "outValid", int'(outValid), 0);
    end
    eV[1] = eV[0]; ePix[1] = ePix[0]; eSof[1] = eSof[0]; eEol[1] = eEol[0];
    eTag[1] = eTag[0]; eTrig[1] = eTrig[0];
    eV[0] = 1'b0;
    // behavioural model of one cycle
    adv   = v || (!mOpen && mDrain > 0);
    carry = v && !mOpen && mDrain > 0;
    if (adv) begin
      hist.push_back(v ? fid * PN + idx : -1);
      pos = hist.size() - 1;
      if (pos >= W + 1 && hist[pos - W - 1] >= 0) begin
        eV[0] = 1'b1;
        expect_pixel(hist[pos - W - 1], ePix[0], eTag[0], eSof[0], eEol[0]);
        eTrig[0] = !v ? "R7" : (carry ? "R9" : "R5");
      end
    end
    if (v && idx == PN - 1) begin
      mOpen = 1'b0; mDrain = W + 1;
    end else begin
      if (v) mOpen = 1'b1;
      if (adv && mDrain > 0) mDrain--;
    end
    inValid = v; inPix = 8'(pix); inSof = sof; inEol = eol;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic send_frame(int f, bit gaps);
    for (int i = 0; i < PN; i++) begin
      if (gaps) idle(rnd8() % 3);
      step(1'b1, img[f][i / W][i % W], i == 0, (i % W) == W - 1, f, i);
    end
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      eV[i] = 1'b0; ePix[i] = 0; eSof[i] = 1'b0; eEol[i] = 1'b0;
      eTag[i] = "R1"; eTrig[i] = "R5";
    end
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        img[0][r][c] = rnd8();
        img[1][r][c] = ((r + c) % 2 == 1) ? 255 : 0;  // R2 both clamp limits
        img[2][r][c] = 20 * r + 10 * c;               // R1 ramp: result equals input
        img[3][r][c] = rnd8();
        img[4][r][c] = rnd8();
        img[5][r][c] = (r == 2 && c == 3) ? 200 : 0;
      end
    repeat (4) @(negedge clk);
    chk(outValid == 1'b0 && outSof == 1'b0 && outEol == 1'b0, "R8", "reset outputs",
        int'({outValid, outSof, outEol}), 0);
    rst = 1'b0;
    send_frame(0, 1'b0);
    idle(2);                // partial drain, next frame carries the rest (R9)
    send_frame(1, 1'b1);
    idle(2);
    send_frame(2, 1'b1);
    idle(W + 4);            // complete drain on idle cycles (R7)
    send_frame(3, 1'b1);
    send_frame(4, 1'b0);    // back to back, no idle cycle (R9)
    send_frame(5, 1'b0);
    idle(W + 6);            // R6: gaps only, nothing further after the drain
    chk(outCount == NF * PN, "R4", "total outputs", outCount, NF * PN);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R5 watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule